// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

A purely combinational adder for two binary floating-point words built from a sign bit, a biased exponent and a fraction. With default parameters the word is 32 bits: sign in bit 31, exponent in bits 30:23 (bias 127) and fraction in bits 22:0. A sign of 1 means negative.

The block places the operand of larger magnitude first. It restores the implicit leading one and shifts the smaller significand right to line up the binary points. It then adds the two significands, or subtracts them in two's complement when the signs differ. The result is renormalised and packed back into a word. Precision is lost only by truncation: no guard, round or sticky bits are kept. Special encodings such as infinities and NaNs are not interpreted, and an exponent field of zero only removes the implicit one.

Typical use is as the arithmetic core of a datapath stage that registers the operands and the result on either side. Everything between those registers is this block.

Top module: `fpadd_core`

## Requirements
- R1: An operand whose exponent field is zero has no implicit leading one. When exactly one operand has a zero exponent field, the result is the other operand word, bit for bit. Results are packed as {sign, exponent, low 23 significand bits}.
- R2: When both exponent fields are zero, the result is the all-zero word, whatever the signs and fractions.
- R3: The operand of larger magnitude leads. Magnitude is compared on bits 30:0 (exponent first, then fraction). On a tie, the first input leads.
- R4: The trailing significand is shifted right by the exponent difference. Bits shifted out are discarded: 1.0 + 1.5·2^-23 gives 0x3F800001.
- R5: For equal signs the significands are added. A carry out increments the exponent and shifts the sum right one place, dropping its LSB. 0x40120000 + 0x40EC0000 gives 0x411A8000.
- R6: For unlike signs the trailing significand is subtracted from the leading one. The difference is shifted left until its MSB is 1, and the shift count is subtracted from the exponent. 0x43008000 + 0xC1920000 gives 0x42DC8000, and 0x3F800000 + 0xBF7FFFFF gives 0x34000000.
- R7: The result sign is the common sign when the signs agree. Otherwise it is the sign of the leading operand, so 1.0 + (-1.5) gives 0xBF000000.
- R8: If an addition carry would make the exponent 255, the result saturates to exponent 254 with an all-ones fraction and the computed sign (0x7F7FFFFF or 0xFF7FFFFF). No result has exponent 255 while both inputs have exponents below 255.
- R9: An exact cancellation gives the all-zero word. A subtraction whose normalised exponent would fall below 1 also gives the all-zero word.
- R10: When the exponent difference is 24 or more, the result is the leading operand word unchanged. At a difference of 23 the datapath still applies: 2^23 + 1.0 gives 0x4B000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand word |
| opb | input | 32 | Second operand word |
| sum | output | 32 | Truncated sum word |

## Verification
Two conditions are hard to reach from the ports. The first is a subtraction that must normalise by many places. The second is one whose exponent drops below one after the leading-one shift. Random operands almost never produce either, because random exponents rarely match and the difference seldom has many leading zeros. The stimulus therefore builds operands directly: nearly equal magnitudes one exponent apart, and minimum-exponent pairs whose difference needs a left shift. Random pairs drawn with exponents within a few steps of each other cover the alignment and carry boundaries around these directed cases.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

   // result source selected by the special-case decoder
   typedef enum logic [2:0] {
      SRC_ZERO  = 3'd0,
      SRC_A     = 3'd1,
      SRC_B     = 3'd2,
      SRC_LEAD  = 3'd3,
      SRC_ARITH = 3'd4
   } fpadd_src_e;

endpackage

// File: rtl/fpadd_order.sv
module fpadd_order #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] in_a,
   input  logic [EXP_W+FRAC_W:0] in_b,
   output logic [EXP_W+FRAC_W:0] lead,
   output logic [EXP_W+FRAC_W:0] trail
);
   localparam int MAG_W = EXP_W + FRAC_W;

   logic a_first;

   always_comb begin
      a_first = (in_a[MAG_W-1:0] >= in_b[MAG_W-1:0]);
      lead    = a_first ? in_a : in_b;
      trail   = a_first ? in_b : in_a;
   end

   always_comb begin
      p_lead_ge_trail_r3: assert (lead[MAG_W-1:0] >= trail[MAG_W-1:0])
         else $error("R3: trailing magnitude exceeds leading magnitude");
   end

endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
   parameter int SIG_W  = 24,
   parameter int CNT_W  = 5,
   parameter bit BARREL = 1'b1
) (
   input  logic [SIG_W-1:0] sig_in,
   input  logic [CNT_W-1:0] amount,
   output logic [SIG_W-1:0] sig_out
);

   generate
      if (BARREL) begin : g_barrel
         logic [SIG_W-1:0] stage [0:CNT_W];
         assign stage[0] = sig_in;
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            assign stage[k+1] = amount[k] ? (stage[k] >> (1 << k)) : stage[k];
         end
         assign sig_out = stage[CNT_W];
      end else begin : g_plain
         assign sig_out = sig_in >> amount;
      end
   endgenerate

   always_comb begin
      p_shift_shrinks_r4: assert (sig_out <= sig_in)
         else $error("R4: aligned significand grew");
      p_zero_shift_r4: assert ((amount != '0) || (sig_out == sig_in))
         else $error("R4: zero shift altered significand");
   end

endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
   parameter int SIG_W = 24,
   parameter int CNT_W = 5
) (
   input  logic [SIG_W-1:0] value,
   output logic [CNT_W-1:0] zeros
);

   // priority encoder: the highest set bit wins because it is visited last
   always_comb begin
      zeros = CNT_W'(SIG_W);
      for (int i = 0; i < SIG_W; i++) begin
         if (value[i]) zeros = CNT_W'(SIG_W - 1 - i);
      end
   end

   always_comb begin
      p_count_hits_one_r6: assert ((value == '0) || (((value << zeros) >> (SIG_W - 1)) == SIG_W'(1)))
         else $error("R6: leading-zero count does not reach the leading one");
   end

endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int CNT_W  = 5
) (
   input  logic                  subtract,
   input  logic                  res_sign,
   input  logic [EXP_W-1:0]      lead_exp,
   input  logic [FRAC_W:0]       lead_sig,
   input  logic [FRAC_W:0]       trail_sig,
   output logic [EXP_W+FRAC_W:0] result
);
   localparam int SIG_W = FRAC_W + 1;
   localparam int EXPX  = EXP_W + 1;
   localparam logic [EXP_W-1:0] EXP_ALL = '1;
   localparam logic [EXP_W-1:0] EXP_TOP = EXP_ALL - EXP_W'(1);

   logic [SIG_W:0]   add_v;
   logic [SIG_W:0]   twos_v;
   logic [SIG_W-1:0] mag;
   logic [SIG_W-1:0] shl;
   logic [CNT_W-1:0] lz;
   logic [EXPX-1:0]  exp_up;
   logic [EXP_W-1:0] exp_dn;

   fpadd_lzc #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_lzc (
      .value (mag),
      .zeros (lz)
   );

   always_comb begin
      add_v  = {1'b0, lead_sig} + {1'b0, trail_sig};
      twos_v = {1'b0, lead_sig} + {1'b0, ~trail_sig} + (SIG_W+1)'(1);
      // carry set: difference is already positive; otherwise negate it
      mag    = twos_v[SIG_W] ? twos_v[SIG_W-1:0] : (~twos_v[SIG_W-1:0] + SIG_W'(1));
      shl    = mag << lz;
      exp_up = {1'b0, lead_exp} + EXPX'(1);
      exp_dn = lead_exp - EXP_W'(lz);

      if (!subtract) begin
         if (add_v[SIG_W]) begin
            if (exp_up[EXP_W] || (exp_up[EXP_W-1:0] == EXP_ALL))
               result = {res_sign, EXP_TOP, {FRAC_W{1'b1}}};
            else
               result = {res_sign, exp_up[EXP_W-1:0], add_v[FRAC_W:1]};
         end else begin
            result = {res_sign, lead_exp, add_v[FRAC_W-1:0]};
         end
      end else if (mag == '0) begin
         result = '0;
      end else if (EXPX'(lz) >= {1'b0, lead_exp}) begin
         result = '0;
      end else begin
         result = {res_sign, exp_dn, shl[FRAC_W-1:0]};
      end
   end

   always_comb begin
      p_norm_lead_one_r6: assert (!subtract || (mag == '0) || shl[SIG_W-1])
         else $error("R6: normalised difference lacks leading one");
      p_add_keeps_one_r5: assert (subtract || !lead_sig[SIG_W-1] || add_v[SIG_W] || add_v[SIG_W-1])
         else $error("R5: sum lost its leading one");
   end

endmodule

// File: rtl/fpadd_core.sv
module fpadd_core #(
   parameter int EXP_W        = 8,
   parameter int FRAC_W       = 23,
   parameter bit BARREL_ALIGN = 1'b1
) (
   input  logic [EXP_W+FRAC_W:0] opa,
   input  logic [EXP_W+FRAC_W:0] opb,
   output logic [EXP_W+FRAC_W:0] sum
);
   import fpadd_pkg::*;

   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int SIG_W = FRAC_W + 1;
   localparam int CNT_W = $clog2(SIG_W + 1);
   localparam logic [EXP_W-1:0] EXP_ALL = '1;

   generate
      if (EXP_W < 3 || FRAC_W < 2 || CNT_W > EXP_W || SIG_W >= (1 << EXP_W)) begin : g_bad_params
         $error("fpadd_core: unsupported EXP_W/FRAC_W combination");
      end
   endgenerate

   logic [W-1:0]     lead, trail;
   logic [EXP_W-1:0] exp_diff;
   logic [SIG_W-1:0] lead_sig, trail_sig, trail_al;
   logic [CNT_W-1:0] shamt;
   logic             a_zero_exp, b_zero_exp, subtract;
   logic [W-1:0]     arith;
   fpadd_src_e       src;

   fpadd_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
      .in_a  (opa),
      .in_b  (opb),
      .lead  (lead),
      .trail (trail)
   );

   always_comb begin
      a_zero_exp = (opa[W-2:FRAC_W] == '0);
      b_zero_exp = (opb[W-2:FRAC_W] == '0);
      exp_diff   = lead[W-2:FRAC_W] - trail[W-2:FRAC_W];
      lead_sig   = {(lead[W-2:FRAC_W]  != '0), lead[FRAC_W-1:0]};
      trail_sig  = {(trail[W-2:FRAC_W] != '0), trail[FRAC_W-1:0]};
      shamt      = exp_diff[CNT_W-1:0];
      subtract   = lead[W-1] ^ trail[W-1];

      if (a_zero_exp && b_zero_exp)        src = SRC_ZERO;
      else if (b_zero_exp)                 src = SRC_A;
      else if (a_zero_exp)                 src = SRC_B;
      else if (exp_diff >= EXP_W'(SIG_W))  src = SRC_LEAD;
      else                                 src = SRC_ARITH;
   end

   fpadd_align #(.SIG_W(SIG_W), .CNT_W(CNT_W), .BARREL(BARREL_ALIGN)) u_align (
      .sig_in  (trail_sig),
      .amount  (shamt),
      .sig_out (trail_al)
   );

   fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_norm (
      .subtract  (subtract),
      .res_sign  (lead[W-1]),
      .lead_exp  (lead[W-2:FRAC_W]),
      .lead_sig  (lead_sig),
      .trail_sig (trail_al),
      .result    (arith)
   );

   always_comb begin
      unique case (src)
         SRC_ZERO:  sum = '0;
         SRC_A:     sum = opa;
         SRC_B:     sum = opb;
         SRC_LEAD:  sum = lead;
         default:   sum = arith;
      endcase
   end

   always_comb begin
      p_pass_other_r1: assert (!(a_zero_exp ^ b_zero_exp) || (sum == (a_zero_exp ? opb : opa)))
         else $error("R1: single zero-exponent operand not passed through");
      p_both_zero_r2: assert (!(a_zero_exp && b_zero_exp) || (sum == '0))
         else $error("R2: zero-exponent pair did not give zero");
      p_no_max_exp_r8: assert ((opa[W-2:FRAC_W] == EXP_ALL) || (opb[W-2:FRAC_W] == EXP_ALL)
                               || (sum[W-2:FRAC_W] != EXP_ALL))
         else $error("R8: result exponent reached all ones");
      p_zero_exp_word_r9: assert ((sum[W-2:FRAC_W] != '0) || (sum == '0))
         else $error("R9: zero exponent with nonzero word");
      p_like_sign_r7: assert ((opa[W-1] != opb[W-1]) || a_zero_exp || b_zero_exp || (sum[W-1] == opa[W-1]))
         else $error("R7: like-sign result changed sign");
   end

endmodule

// File: tb/sim_fpadd_core.sv
module sim_fpadd_core;

   typedef struct {
      logic [31:0] want;
      logic [31:0] a;
      logic [31:0] b;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [31:0] sum;
   item_t       sb [$];
   int          total = 0;
   int          bad = 0;
   int          cycles = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   fpadd_core u0 (.opa(opa), .opb(opb), .sum(sum));

   // truncating reference model written from the requirements
   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
      int unsigned ea, eb, el, et, d;
      longint      ml, mt, s;
      int          e;
      logic [31:0] lw, tw;
      ea = a[30:23]; eb = b[30:23];
      if (ea == 0 && eb == 0) return 32'h0;
      if (ea == 0) return b;
      if (eb == 0) return a;
      if (a[30:0] >= b[30:0]) begin lw = a; tw = b; end
      else begin lw = b; tw = a; end
      el = lw[30:23]; et = tw[30:23];
      d = el - et;
      if (d >= 24) return lw;
      ml = longint'(lw[22:0]) + 64'd8388608;
      mt = (longint'(tw[22:0]) + 64'd8388608) >> d;
      e = int'(el);
      if (lw[31] == tw[31]) begin
         s = ml + mt;
         if (s >= 64'd16777216) begin s = s >> 1; e = e + 1; end
         if (e >= 255) return {lw[31], 8'hFE, 23'h7FFFFF};
      end else begin
         s = ml - mt;
         if (s == 0) return 32'h0;
         while (s < 64'd8388608) begin s = s << 1; e = e - 1; end
         if (e < 1) return 32'h0;
      end
      return {lw[31], 8'(e), s[22:0]};
   endfunction

   task automatic send(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] want, input string tag);
      item_t it;
      @(posedge clk);
      opa <= a;
      opb <= b;
      it.want = want; it.a = a; it.b = b; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic send_model(input logic [31:0] a, input logic [31:0] b, input string tag);
      send(a, b, model(a, b), tag);
   endtask

   // monitor: compare half a cycle after each drive
   always @(negedge clk) begin
      if (!rst && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         total++;
         if (sum !== it.want) begin
            bad++;
            $display("FAIL %s: a=%h b=%h got=%h exp=%h", it.tag, it.a, it.b, sum, it.want);
         end
      end
   end

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: idle operands produce zero
      send(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, "R2 idle");
      // worked cases
      send(32'h4012_0000, 32'h40EC_0000, 32'h411A_8000, "R5 like-sign carry");
      send(32'h4300_8000, 32'hC192_0000, 32'h42DC_8000, "R6 unlike signs");
      send(32'h3F80_0000, 32'hBF7F_FFFF, 32'h3400_0000, "R6 deep normalise");
      // R1 and R2
      send(32'h0000_0123, 32'hC040_0000, 32'hC040_0000, "R1 pass b");
      send(32'h4120_0000, 32'h8000_7777, 32'h4120_0000, "R1 pass a");
      send(32'h8000_0555, 32'h0000_0001, 32'h0000_0000, "R2 both zero exp");
      // R3 ordering and R7 sign
      send(32'h3F80_0000, 32'hBFC0_0000, 32'hBF00_0000, "R7 sign of larger");
      send(32'hBFC0_0000, 32'h3F80_0000, 32'hBF00_0000, "R3 swapped order");
      send(32'hC000_0000, 32'hBF80_0000, 32'hC040_0000, "R7 negative like-sign");
      // R4 truncation on alignment
      send(32'h3F80_0000, 32'h3440_0000, 32'h3F80_0001, "R4 truncated shift");
      // R8 saturation
      send(32'h7F7F_FFFF, 32'h7F7F_FFFF, 32'h7F7F_FFFF, "R8 positive saturate");
      send(32'hFF7F_FFFF, 32'hFF7F_FFFF, 32'hFF7F_FFFF, "R8 negative saturate");
      // R9 cancellation and flush
      send(32'h3FC0_0000, 32'hBFC0_0000, 32'h0000_0000, "R9 exact cancel");
      send(32'h00C0_0000, 32'h8080_0000, 32'h0000_0000, "R9 flush below one");
      // R10 bypass boundary
      send(32'h4B80_0000, 32'h3F80_0000, 32'h4B80_0000, "R10 diff 24");
      send(32'h4B00_0000, 32'h3F80_0000, 32'h4B00_0001, "R10 diff 23");
      // random pairs with nearby exponents
      for (int n = 0; n < 400; n++) begin
         logic [31:0] a, b;
         int unsigned ea, eb;
         ea = 2 + ($urandom % 250);
         eb = ea + ($urandom % 31);
         eb = (eb > 15) ? eb - 15 : 1;
         if (eb > 254) eb = 254;
         a = {1'($urandom), 8'(ea), 23'($urandom)};
         b = {1'($urandom), 8'(eb), 23'($urandom)};
         if (n % 4 == 0) b[31] = ~a[31];
         send_model(a, b, (n % 2 == 0) ? "R5 random" : "R6 random");
      end
      while (sb.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule